// File: doc/BRIEF.md
# Power-Stage Protection Fault Manager

This block sits beside the gate driver of a synchronous buck power stage and turns raw protection comparators into one decision. It watches four kinds of trouble: overcurrent in a switching cycle, a switch node that stays high while the low-side gate is on, over-temperature, and supply undervoltage. It drives a two-bit monitor pin state, a per-cycle duty-truncate request and a driver-off signal. Analog sensing happens elsewhere. Every time window is counted in clock cycles.

Three fault sources feed one sticky latch: repeated overcurrent truncation, a high-side short, and sustained heat. Once set, the latch holds the monitor state at FAULT. Only a supply recycle clears it. A recycle is a rising edge on either the logic-supply-valid input or the driver-supply-valid input. When no fault is latched, the monitor state is LOW or TEMP, and the choice follows the supply sequencing rules. Thermal faults also force the driver off.

Top module: `pstage_fault_mgr`

## Requirements
- R1: `trunc_req` is high in exactly the clock cycles where `oc_hit` is high and `drv_kill` is low. It is combinational, with no added latency.
- R2: A cycle counts as truncated if `oc_hit` was high in any clock of that switching cycle, including the strobe clock. A cycle ends with a `cyc_strobe` pulse. After `TRUNC_LIMIT` (10) consecutive truncated cycles, the fault latches and `mon_state` reads FAULT after the clock edge of the final strobe. One untruncated strobe resets the run to zero.
- R3: If `ls_on` and `sw_high` are both high on a clock edge while the logic supply is valid, the fault latches and `mon_state` reads FAULT after that edge. `sw_high` while `ls_on` is low has no effect.
- R4: If `ot_hot` stays high for `OT_DGL` consecutive clocks, the fault latches and `drv_kill` goes high. A shorter run latches nothing and leaves `drv_kill` low.
- R5: A latched fault stays until a recycle. A recycle is a 0-to-1 change of `logic_ok` or `drv_ok`. It clears every fault latch, the truncation run, the thermal deglitch count and the partial-cycle overcurrent flag.
- R6: While `logic_ok` is low and no fault is latched, `mon_state` is LOW and `drv_kill` is high. The fault detectors ignore their inputs during this time.
- R7: Once `logic_ok` is high, `mon_state` stays LOW and `drv_kill` stays high until `drv_ok` is seen high at a clock edge. From the next cycle, `mon_state` is TEMP and `drv_kill` is low.
- R8: After the driver supply has come up, `drv_ok` may go low again. The state stays TEMP until `drv_ok` has been low through `DRV_LOST_CYC` (3) strobes or through `DRV_TMO` clocks, whichever comes first. At that point `mon_state` drops to LOW and `drv_kill` goes high.
- R9: `mon_state` encodes LOW as 2'b00, TEMP as 2'b01 and FAULT as 2'b10, and never shows 2'b11. FAULT takes priority over TEMP and LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| logic_ok | input | 1 | Logic supply above its UVLO threshold |
| drv_ok | input | 1 | Driver supply above its UVLO threshold |
| cyc_strobe | input | 1 | One-clock pulse marking the end of a switching cycle |
| oc_hit | input | 1 | Current above the trip level |
| ls_on | input | 1 | Low-side gate is on |
| sw_high | input | 1 | Switch node above the short-detect threshold |
| ot_hot | input | 1 | Temperature above the trip level |
| mon_state | output | 2 | Monitor pin state: 00 LOW, 01 TEMP, 10 FAULT |
| trunc_req | output | 1 | Truncate the current duty cycle |
| drv_kill | output | 1 | Force both gates off |

## Verification
Suppose the truncation run or the thermal deglitch count is off by one. Then FAULT appears one strobe or one clock early or late. The bench sweeps run lengths on both sides of each limit, so that edge shows directly. A latch that clears when it should not, or a recycle that is missed, shows up within a single clock as TEMP where FAULT was expected, or the reverse. A wrong driver-loss counter moves the TEMP-to-LOW drop away from the third strobe or the timeout clock.

// File: rtl/pstage_fault_mgr.sv
module pstage_fault_mgr #(
  parameter int TRUNC_LIMIT  = 10,
  parameter int OT_DGL       = 800,
  parameter int DRV_TMO      = 1500,
  parameter int DRV_LOST_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       logic_ok,
  input  logic       drv_ok,
  input  logic       cyc_strobe,
  input  logic       oc_hit,
  input  logic       ls_on,
  input  logic       sw_high,
  input  logic       ot_hot,
  output logic [1:0] mon_state,
  output logic       trunc_req,
  output logic       drv_kill
);
  localparam int TW = $clog2(TRUNC_LIMIT + 1);
  localparam int OW = $clog2(OT_DGL + 1);
  localparam int DW = $clog2(DRV_TMO + 1);
  localparam int LW = $clog2(DRV_LOST_CYC + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TRUNC_LIMIT - 1);
  localparam logic [OW-1:0] O_LAST = OW'(OT_DGL - 1);
  localparam logic [DW-1:0] D_LAST = DW'(DRV_TMO - 1);
  localparam logic [LW-1:0] L_LAST = LW'(DRV_LOST_CYC - 1);
  localparam logic [1:0] MON_LOW   = 2'b00;
  localparam logic [1:0] MON_TEMP  = 2'b01;
  localparam logic [1:0] MON_FAULT = 2'b10;

  logic          logic_q, drv_q, rcy;
  logic          oc_seen, trunc_cyc;
  logic [TW-1:0] tcnt;
  logic [OW-1:0] otcnt;
  logic [DW-1:0] dtmr;
  logic [LW-1:0] lcnt;
  logic          drv_up;
  logic          flt_oc, flt_ot, flt_hs, fault;

  assign rcy       = (logic_ok & ~logic_q) | (drv_ok & ~drv_q);
  assign trunc_cyc = oc_seen | oc_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      logic_q <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      logic_q <= logic_ok;
      drv_q   <= drv_ok;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_seen <= 1'b0;
      tcnt    <= '0;
      flt_oc  <= 1'b0;
    end else if (rcy || !logic_ok) begin
      oc_seen <= 1'b0;
      tcnt    <= '0;
      if (rcy) flt_oc <= 1'b0;
    end else if (cyc_strobe) begin
      oc_seen <= 1'b0;
      if (trunc_cyc) begin
        if (tcnt == T_LAST) flt_oc <= 1'b1;
        else                tcnt   <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
      end
    end else if (oc_hit) begin
      oc_seen <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      otcnt  <= '0;
      flt_ot <= 1'b0;
    end else if (rcy) begin
      otcnt  <= '0;
      flt_ot <= 1'b0;
    end else if (!ot_hot || !logic_ok) begin
      otcnt <= '0;
    end else if (otcnt == O_LAST) begin
      flt_ot <= 1'b1;
    end else begin
      otcnt <= otcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          flt_hs <= 1'b0;
    else if (rcy)                        flt_hs <= 1'b0;
    else if (logic_ok && ls_on && sw_high) flt_hs <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drv_up <= 1'b0;
      dtmr   <= '0;
      lcnt   <= '0;
    end else if (!logic_ok) begin
      drv_up <= 1'b0;
      dtmr   <= '0;
      lcnt   <= '0;
    end else if (drv_ok) begin
      drv_up <= 1'b1;
      dtmr   <= '0;
      lcnt   <= '0;
    end else begin
      if (dtmr != D_LAST)                   dtmr <= dtmr + 1'b1;
      if (cyc_strobe && lcnt != L_LAST)     lcnt <= lcnt + 1'b1;
      if (dtmr == D_LAST || (cyc_strobe && lcnt == L_LAST)) drv_up <= 1'b0;
    end

  assign fault     = flt_oc | flt_ot | flt_hs;
  assign drv_kill  = ~logic_ok | ~drv_up | flt_ot;
  assign trunc_req = oc_hit & ~drv_kill;
  assign mon_state = fault ? MON_FAULT : ((logic_ok & drv_up) ? MON_TEMP : MON_LOW);
endmodule

// File: rtl/pstage_fault_mgr_chk.sv
module pstage_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       logic_ok,
  input logic       ls_on,
  input logic       sw_high,
  input logic       oc_hit,
  input logic       rcy,
  input logic [1:0] mon_state,
  input logic       trunc_req,
  input logic       drv_kill
);
  a_r1_trunc_follows_oc: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_hit && mon_state == 2'b01) |-> trunc_req);

  a_r3_short_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (logic_ok && ls_on && sw_high && !rcy) |=> (mon_state == 2'b10));

  a_r5_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == 2'b10 && !rcy) |=> (mon_state == 2'b10));

  a_r6_low_without_logic: assert property (@(posedge clk) disable iff (!rst_n)
    (!logic_ok && mon_state != 2'b10) |-> (mon_state == 2'b00 && drv_kill));

  a_r9_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    mon_state != 2'b11);

  a_r7_temp_runs_driver: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_state == 2'b01) |-> !drv_kill);
endmodule

bind pstage_fault_mgr pstage_fault_mgr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .logic_ok  (logic_ok),
  .ls_on     (ls_on),
  .sw_high   (sw_high),
  .oc_hit    (oc_hit),
  .rcy       (rcy),
  .mon_state (mon_state),
  .trunc_req (trunc_req),
  .drv_kill  (drv_kill)
);

// File: tb/tb_pstage_fault_mgr.sv
`timescale 1ns/1ps
module tb_pstage_fault_mgr;
  localparam int TL = 10, OD = 8, DT = 20, LC = 3;
  localparam int LOW = 0, TEMP = 1, FAULT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic logic_ok = 1'b0, drv_ok = 1'b0, cyc_strobe = 1'b0, oc_hit = 1'b0;
  logic ls_on = 1'b0, sw_high = 1'b0, ot_hot = 1'b0;
  logic [1:0] mon_state;
  logic trunc_req, drv_kill;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pstage_fault_mgr #(.TRUNC_LIMIT(TL), .OT_DGL(OD), .DRV_TMO(DT), .DRV_LOST_CYC(LC)) dut (
    .clk(clk), .rst_n(rst_n), .logic_ok(logic_ok), .drv_ok(drv_ok),
    .cyc_strobe(cyc_strobe), .oc_hit(oc_hit), .ls_on(ls_on), .sw_high(sw_high),
    .ot_hot(ot_hot), .mon_state(mon_state), .trunc_req(trunc_req), .drv_kill(drv_kill));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic recycle();
    drv_ok = 1'b0; tick();
    drv_ok = 1'b1; tick();
  endtask

  // one switching cycle: optional mid-cycle oc pulse, then strobe with optional oc
  task automatic strobe(input bit oc_mid, input bit oc_at);
    oc_hit = oc_mid; tick();
    oc_hit = 1'b0;   tick();
    cyc_strobe = 1'b1; oc_hit = oc_at; tick();
    cyc_strobe = 1'b0; oc_hit = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R6 reset mon", mon_state, LOW);
    chk("R6 reset kill", drv_kill, 1);
    oc_hit = 1'b1; #1;
    chk("R1 no trunc while killed", trunc_req, 0);
    oc_hit = 1'b0;
    ls_on = 1'b1; sw_high = 1'b1; tick(2);
    chk("R6 short ignored without logic", mon_state, LOW);
    ls_on = 1'b0; sw_high = 1'b0;

    logic_ok = 1'b1; tick(3);
    chk("R7 low before driver", mon_state, LOW);
    chk("R7 kill before driver", drv_kill, 1);
    drv_ok = 1'b1; tick();
    chk("R7 temp after driver", mon_state, TEMP);
    chk("R7 driver enabled", drv_kill, 0);
    oc_hit = 1'b1; #1;
    chk("R1 trunc follows oc", trunc_req, 1);
    oc_hit = 1'b0; #1;
    chk("R1 trunc drops", trunc_req, 0);
    tick();

    // R2 sweep of run lengths
    for (int n = 0; n <= 12; n++) begin
      recycle();
      chk("R5 recycle to temp", mon_state, TEMP);
      for (int k = 1; k <= n; k++) begin
        strobe(k[0], !k[0]);
        chk("R2 run length", mon_state, (k >= TL) ? FAULT : TEMP);
      end
      strobe(1'b0, 1'b0);
      chk("R5 sticky after clean cycle", mon_state, (n >= TL) ? FAULT : TEMP);
      chk("R2 oc fault keeps driver", drv_kill, 0);
    end

    // R2 reset of the run by a clean cycle
    recycle();
    for (int k = 0; k < TL - 1; k++) strobe(1'b0, 1'b1);
    strobe(1'b0, 1'b0);
    for (int k = 0; k < TL - 1; k++) strobe(1'b1, 1'b0);
    chk("R2 clean cycle resets run", mon_state, TEMP);
    strobe(1'b0, 1'b1);
    chk("R2 tenth after reset", mon_state, FAULT);
    tick(30);
    chk("R5 fault holds", mon_state, FAULT);

    // R5 recycle clears a partial run
    recycle();
    for (int k = 0; k < TL - 1; k++) strobe(1'b0, 1'b1);
    recycle();
    for (int k = 0; k < TL - 1; k++) strobe(1'b0, 1'b1);
    chk("R5 recycle clears run", mon_state, TEMP);

    // R3 all combinations of ls_on / sw_high
    for (int c = 0; c < 4; c++) begin
      recycle();
      ls_on = c[0]; sw_high = c[1]; tick();
      ls_on = 1'b0; sw_high = 1'b0;
      chk("R3 short detect", mon_state, (c == 3) ? FAULT : TEMP);
      tick(3);
      chk("R3 short stays", mon_state, (c == 3) ? FAULT : TEMP);
    end

    // R4 deglitch sweep
    for (int len = 1; len <= OD + 2; len++) begin
      recycle();
      ot_hot = 1'b1; tick(len);
      ot_hot = 1'b0;
      chk("R4 thermal mon", mon_state, (len >= OD) ? FAULT : TEMP);
      chk("R4 thermal kill", drv_kill, (len >= OD) ? 1 : 0);
      tick(2);
    end
    recycle();
    chk("R5 thermal cleared", drv_kill, 0);

    // R8 loss by strobes
    drv_ok = 1'b0;
    strobe(1'b0, 1'b0);
    strobe(1'b0, 1'b0);
    chk("R8 two strobes keep temp", mon_state, TEMP);
    strobe(1'b0, 1'b0);
    chk("R8 third strobe drops", mon_state, LOW);
    chk("R8 kill after loss", drv_kill, 1);
    drv_ok = 1'b1; tick();
    chk("R7 driver back", mon_state, TEMP);

    // R8 loss by timeout
    drv_ok = 1'b0; tick(DT - 1);
    chk("R8 before timeout", mon_state, TEMP);
    tick();
    chk("R8 at timeout", mon_state, LOW);
    // R9 fault priority over LOW
    ls_on = 1'b1; sw_high = 1'b1; tick();
    ls_on = 1'b0; sw_high = 1'b0;
    chk("R9 fault over low", mon_state, FAULT);
    logic_ok = 1'b0; tick();
    chk("R9 fault over logic loss", mon_state, FAULT);
    logic_ok = 1'b1; tick();
    chk("R5 logic recycle clears", mon_state, LOW);
    drv_ok = 1'b1; tick();
    chk("R7 temp after full recycle", mon_state, TEMP);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule